// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation table kept in ordinary memory. A request carries the virtual address, the kind of access (read or write, user or supervisor) and the frame number of the top-level table. The walker reads the top-level entry and then, unless that entry maps a large page on its own, reads the second-level entry. It returns either a physical address together with the two cache-policy bits of the final entry, or a fault with a cause code.

On a successful translation, the walker keeps the usage bits in memory up to date. It sets the accessed flag in each entry it used, and it sets the modified flag in the final entry when the access is a write. Each of these flags is written only when it was clear before. A faulting walk never writes to memory.

The memory side is one word-wide port with a valid/ready handshake. Every read, and every write-back, is a single handshake. Requests are taken one at a time, and the response is a one-cycle pulse.

Top module: `pt_walker`

## Requirements
- R1: Entry layout, used at both levels: bit 0 present, bit 1 writable, bit 2 user-accessible, bit 3 write-through, bit 4 cache-disable, bit 5 accessed, bit 6 modified, bit 7 large page (top level only), bits 31:12 frame number. The top-level entry is read from word address {req_base, vaddr[31:22], 2'b00}.
- R2: For a top-level entry with bit 7 clear, the second-level entry is read from {top frame, vaddr[21:12], 2'b00}. The physical address is {second-level frame, vaddr[11:0]}.
- R3: A clear present bit in the top-level entry faults with cause 0. A clear present bit in the second-level entry faults with cause 1. Every fault reports physical address 0.
- R4: The effective writable and user rights are the AND of the entries used. A user access without user rights faults with cause 3, and this cause wins over a write fault. Any write without writable rights faults with cause 2. A supervisor read of a present mapping never faults. Rights are checked only after presence has been confirmed at every level walked.
- R5: A present top-level entry with bit 7 set maps a 4 MB page. No second read is made, the rights come from that entry alone, and the physical address is {entry[31:22], vaddr[21:0]}.
- R6: After a successful 4 KB walk whose top-level entry has bit 5 clear, that entry is written back with bit 5 set and is otherwise unchanged. This write comes before any write to the final entry.
- R7: After a success, the final entry is written back only when bit 5 is clear, or when the access is a write and bit 6 is clear. The written value has bit 5 set, has bit 6 set on a write, and is otherwise unchanged. A read never sets bit 6, and a fault leaves memory untouched.
- R8: On success, resp_pwt and resp_pcd carry bits 3 and 4 of the final entry. On a fault, both are 0.
- R9: A memory request holds its address, direction and data until mem_ready is high. Read data is taken in the cycle in which mem_ready is high.
- R10: req_ready is high only while idle, and resp_valid is a one-cycle pulse. With mem_ready high in every cycle that has a request, resp_valid rises this many clock edges after the accepting edge: 2 for a top-level fault or a 4 MB page, 4 for a second-level fault or a 4 KB page, plus one per write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle; request accepted when both are high |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_user | input | 1 | 1 for a user-mode access, 0 for supervisor |
| req_base | input | 20 | Frame number of the top-level table |
| resp_valid | output | 1 | One-cycle result pulse |
| resp_fault | output | 1 | Translation failed |
| resp_cause | output | 2 | Fault cause: 0 top absent, 1 second absent, 2 write, 3 user |
| resp_paddr | output | 32 | Translated physical address |
| resp_pwt | output | 1 | Write-through bit of the final entry |
| resp_pcd | output | 1 | Cache-disable bit of the final entry |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory accepts the request (and returns read data) |
| mem_write | output | 1 | 1 for a write-back, 0 for a read |
| mem_addr | output | 32 | Byte address of the entry word |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Read data, valid while mem_ready is high |

## Verification
A response is due a fixed number of edges after acceptance when memory answers without wait. That number is two edges per level walked, plus one edge per write-back. In a zero-wait batch, the bench counts edges from the accepting edge to the falling edge where resp_valid is first seen, and compares the count with that sum. In the batches with random memory stalls, the bench waits for the pulse instead. For every walk, it then samples the response and the entry words on a falling edge after the final write-back has completed. It also counts the memory writes made during that walk.

// File: rtl/pt_walker_pkg.sv
// Shared definitions for the translation walker: entry flag positions,
// fault cause codes and the walk state encoding.
package pt_walker_pkg;

    localparam int BIT_P   = 0;
    localparam int BIT_W   = 1;
    localparam int BIT_U   = 2;
    localparam int BIT_PWT = 3;
    localparam int BIT_PCD = 4;
    localparam int BIT_A   = 5;
    localparam int BIT_D   = 6;
    localparam int BIT_PS  = 7;

    typedef enum logic [1:0] {
        CAUSE_NP_DIR = 2'd0,
        CAUSE_NP_TBL = 2'd1,
        CAUSE_WRITE  = 2'd2,
        CAUSE_USER   = 2'd3
    } fault_cause_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_CHK_DIR,
        ST_RD_TBL,
        ST_CHK_TBL,
        ST_WB_DIR,
        ST_WB_LEAF,
        ST_RESP
    } walk_state_e;

endpackage

// File: rtl/pt_addr_gen.sv
// Address formation for the walker. Pure combinational logic.
// Assumes that a top-level index and a second-level index, each with a
// two-bit word offset appended, fill exactly one page offset.
module pt_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 12,
    parameter int IDX_W  = 10,
    localparam int FRAME_W = ADDR_W - OFFS_W,
    localparam int LARGE_W = OFFS_W + IDX_W
) (
    input  logic [FRAME_W-1:0] base_frame_i,
    input  logic [ADDR_W-1:0]  vaddr_i,
    input  logic [FRAME_W-1:0] dir_frame_i,
    input  logic [FRAME_W-1:0] leaf_frame_i,
    output logic [ADDR_W-1:0]  dir_addr_o,
    output logic [ADDR_W-1:0]  tbl_addr_o,
    output logic [ADDR_W-1:0]  pa_small_o,
    output logic [ADDR_W-1:0]  pa_large_o
);

    // Entry word addresses and the physical addresses for both page sizes.
    always_comb begin
        dir_addr_o = {base_frame_i, vaddr_i[ADDR_W-1:LARGE_W], 2'b00};
        tbl_addr_o = {dir_frame_i, vaddr_i[LARGE_W-1:OFFS_W], 2'b00};
        pa_small_o = {leaf_frame_i, vaddr_i[OFFS_W-1:0]};
        pa_large_o = {dir_frame_i[FRAME_W-1:IDX_W], vaddr_i[LARGE_W-1:0]};
    end

endmodule

// File: rtl/pt_perm_check.sv
// Per-level presence and rights check. The writable and user rights
// arriving from the level above are narrowed by this entry's own bits.
// Assumes flags_i holds entry bits 2:0 (present, writable, user).
module pt_perm_check (
    input  logic [2:0] flags_i,
    input  logic       w_in_i,
    input  logic       u_in_i,
    input  logic       write_i,
    input  logic       user_i,
    output logic       present_o,
    output logic       w_o,
    output logic       u_o,
    output logic       write_fault_o,
    output logic       user_fault_o
);

    // Narrow the rights and flag any violation for this access.
    always_comb begin
        present_o     = flags_i[0];
        w_o           = w_in_i & flags_i[1];
        u_o           = u_in_i & flags_i[2];
        write_fault_o = write_i & ~w_o;
        user_fault_o  = user_i & ~u_o;
    end

endmodule

// File: rtl/pt_walker.sv
// Two-level translation walker. It reads the top-level entry, then
// either stops at a large page or reads the second-level entry. It checks
// presence and rights, then writes back the accessed and modified flags
// that were clear. Assumes memory answers reads in the handshake cycle.
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 12,
    parameter int IDX_W  = 10,
    localparam int FRAME_W = ADDR_W - OFFS_W,
    localparam int LEVELS  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_vaddr,
    input  logic               req_write,
    input  logic               req_user,
    input  logic [FRAME_W-1:0] req_base,
    output logic               resp_valid,
    output logic               resp_fault,
    output logic [1:0]         resp_cause,
    output logic [ADDR_W-1:0]  resp_paddr,
    output logic               resp_pwt,
    output logic               resp_pcd,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic               mem_write,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [ADDR_W-1:0]  mem_wdata,
    input  logic [ADDR_W-1:0]  mem_rdata
);

    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(1) << BIT_A;
    localparam logic [ADDR_W-1:0] D_MASK = ADDR_W'(1) << BIT_D;

    walk_state_e        state_q;
    logic [ADDR_W-1:0]  va_q;
    logic               wr_q;
    logic               usr_q;
    logic [FRAME_W-1:0] base_q;
    logic [ADDR_W-1:0]  pde_q;
    logic [ADDR_W-1:0]  pte_q;
    logic [ADDR_W-1:0]  paddr_q;
    logic               fault_q;
    fault_cause_e       cause_q;
    logic               pwt_q;
    logic               pcd_q;

    logic [ADDR_W-1:0]  dir_addr, tbl_addr, pa_small, pa_large, leaf;
    logic               need_dir_wb, need_leaf_wb;
    logic               chk_fault;
    fault_cause_e       chk_cause;

    logic [ADDR_W-1:0]  lvl_entry [LEVELS];
    logic [LEVELS-1:0]  lvl_present, lvl_wfault, lvl_ufault;
    logic [LEVELS-1:0]  w_in, u_in, w_out, u_out;

    pt_addr_gen #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .IDX_W(IDX_W)) u_addr (
        .base_frame_i (base_q),
        .vaddr_i      (va_q),
        .dir_frame_i  (pde_q[ADDR_W-1:OFFS_W]),
        .leaf_frame_i (pte_q[ADDR_W-1:OFFS_W]),
        .dir_addr_o   (dir_addr),
        .tbl_addr_o   (tbl_addr),
        .pa_small_o   (pa_small),
        .pa_large_o   (pa_large)
    );

    assign lvl_entry[0] = pde_q;
    assign lvl_entry[1] = pte_q;
    assign w_in = {w_out[0], 1'b1};
    assign u_in = {u_out[0], 1'b1};

    // One rights checker per level, chained from the top level downwards.
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        pt_perm_check u_chk (
            .flags_i       (lvl_entry[g][2:0]),
            .w_in_i        (w_in[g]),
            .u_in_i        (u_in[g]),
            .write_i       (wr_q),
            .user_i        (usr_q),
            .present_o     (lvl_present[g]),
            .w_o           (w_out[g]),
            .u_o           (u_out[g]),
            .write_fault_o (lvl_wfault[g]),
            .user_fault_o  (lvl_ufault[g])
        );
    end

    // Final entry selection and the write-back needs it implies.
    always_comb begin
        leaf         = pde_q[BIT_PS] ? pde_q : pte_q;
        need_dir_wb  = ~pde_q[BIT_A];
        need_leaf_wb = ~leaf[BIT_A] | (wr_q & ~leaf[BIT_D]);
    end

    // Fault decision for the level under check, presence before rights.
    always_comb begin
        int lvl;
        lvl       = (state_q == ST_CHK_TBL) ? 1 : 0;
        chk_fault = 1'b1;
        if (!lvl_present[lvl]) begin
            chk_cause = (lvl == 0) ? CAUSE_NP_DIR : CAUSE_NP_TBL;
        end else if (lvl_ufault[lvl]) begin
            chk_cause = CAUSE_USER;
        end else if (lvl_wfault[lvl]) begin
            chk_cause = CAUSE_WRITE;
        end else begin
            chk_cause = CAUSE_NP_DIR;
            chk_fault = 1'b0;
        end
    end

    // Walk sequencing and capture of entries and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            va_q    <= '0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            base_q  <= '0;
            pde_q   <= '0;
            pte_q   <= '0;
            paddr_q <= '0;
            fault_q <= 1'b0;
            cause_q <= CAUSE_NP_DIR;
            pwt_q   <= 1'b0;
            pcd_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    va_q    <= req_vaddr;
                    wr_q    <= req_write;
                    usr_q   <= req_user;
                    base_q  <= req_base;
                    state_q <= ST_RD_DIR;
                end
                ST_RD_DIR: if (mem_ready) begin
                    pde_q   <= mem_rdata;
                    state_q <= ST_CHK_DIR;
                end
                ST_CHK_DIR: begin
                    if (chk_fault && (!pde_q[BIT_P] || pde_q[BIT_PS])) begin
                        fault_q <= 1'b1;
                        cause_q <= chk_cause;
                        paddr_q <= '0;
                        pwt_q   <= 1'b0;
                        pcd_q   <= 1'b0;
                        state_q <= ST_RESP;
                    end else if (pde_q[BIT_PS]) begin
                        fault_q <= 1'b0;
                        paddr_q <= pa_large;
                        pwt_q   <= leaf[BIT_PWT];
                        pcd_q   <= leaf[BIT_PCD];
                        state_q <= need_leaf_wb ? ST_WB_LEAF : ST_RESP;
                    end else begin
                        state_q <= ST_RD_TBL;
                    end
                end
                ST_RD_TBL: if (mem_ready) begin
                    pte_q   <= mem_rdata;
                    state_q <= ST_CHK_TBL;
                end
                ST_CHK_TBL: begin
                    if (chk_fault) begin
                        fault_q <= 1'b1;
                        cause_q <= chk_cause;
                        paddr_q <= '0;
                        pwt_q   <= 1'b0;
                        pcd_q   <= 1'b0;
                        state_q <= ST_RESP;
                    end else begin
                        fault_q <= 1'b0;
                        paddr_q <= pa_small;
                        pwt_q   <= leaf[BIT_PWT];
                        pcd_q   <= leaf[BIT_PCD];
                        state_q <= need_dir_wb  ? ST_WB_DIR  :
                                   need_leaf_wb ? ST_WB_LEAF : ST_RESP;
                    end
                end
                ST_WB_DIR: if (mem_ready) begin
                    state_q <= need_leaf_wb ? ST_WB_LEAF : ST_RESP;
                end
                ST_WB_LEAF: if (mem_ready) begin
                    state_q <= ST_RESP;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Memory port request for the current state.
    always_comb begin
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_addr  = dir_addr;
        mem_wdata = '0;
        case (state_q)
            ST_RD_DIR: mem_valid = 1'b1;
            ST_RD_TBL: begin
                mem_valid = 1'b1;
                mem_addr  = tbl_addr;
            end
            ST_WB_DIR: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_wdata = pde_q | A_MASK;
            end
            ST_WB_LEAF: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = pde_q[BIT_PS] ? dir_addr : tbl_addr;
                mem_wdata = leaf | A_MASK | (wr_q ? D_MASK : '0);
            end
            default: ;
        endcase
    end

    // Response and request-side outputs.
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        resp_valid = (state_q == ST_RESP);
        resp_fault = fault_q;
        resp_cause = cause_q;
        resp_paddr = paddr_q;
        resp_pwt   = pwt_q;
        resp_pcd   = pcd_q;
    end

endmodule

// File: rtl/pt_walker_chk.sv
// Protocol and result checks for the walker, attached by bind.
module pt_walker_chk
    import pt_walker_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        resp_valid,
    input logic        resp_fault,
    input logic [31:0] resp_paddr,
    input logic        resp_pwt,
    input logic        resp_pcd,
    input logic        mem_valid,
    input logic        mem_ready,
    input logic        mem_write,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata
);

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)); // R9

    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_valid); // R9

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid && req_ready); // R10

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready && !resp_valid); // R10

    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_fault |-> resp_paddr == 32'd0 && !resp_pwt && !resp_pcd); // R3

    AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_write |-> mem_wdata[BIT_A] && mem_wdata[BIT_P]); // R6

endmodule

bind pt_walker pt_walker_chk i_pt_walker_chk (.*);

// File: tb/test_pt_walker.sv
module test_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write, req_user;
    logic [31:0] req_vaddr;
    logic [19:0] req_base;
    logic        resp_valid, resp_fault, resp_pwt, resp_pcd;
    logic [1:0]  resp_cause;
    logic [31:0] resp_paddr;
    logic        mem_valid, mem_ready, mem_write;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;
    int wcount = 0;
    bit zero_wait = 1'b1;
    logic [31:0] mem [0:4095];

    always #5 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user), .req_base(req_base),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_cause(resp_cause),
        .resp_paddr(resp_paddr), .resp_pwt(resp_pwt), .resp_pcd(resp_pcd),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [11:0] widx(logic [31:0] a);
        return a[13:2];
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Translate with a model built from the requirements and compare.
    task automatic run_walk(logic [19:0] base, logic [31:0] va, logic wr, logic usr, bit lat_chk);
        logic [31:0] pa1, pa2, pde, pte, leaf, exp_pa, new_pde, new_leaf;
        logic ef, ew, eu, epwt, epcd;
        logic [1:0] ec;
        int exp_w, exp_lat, lat, w0;
        bit done;
        pa1 = {base, va[31:22], 2'b00};
        pde = mem[widx(pa1)];
        pa2 = {pde[31:12], va[21:12], 2'b00};
        pte = mem[widx(pa2)];
        ef = 0; ec = 0; ew = 0; eu = 0; exp_w = 0; exp_pa = 0; epwt = 0; epcd = 0;
        new_pde = pde; new_leaf = pte; leaf = pde; exp_lat = 2;
        if (!pde[0]) begin
            ef = 1; ec = 0;
        end else begin
            if (pde[7]) begin
                leaf = pde; ew = pde[1]; eu = pde[2];
            end else begin
                exp_lat = 4;
                leaf = pte; ew = pde[1] & pte[1]; eu = pde[2] & pte[2];
                if (!pte[0]) begin ef = 1; ec = 1; end
            end
            if (!ef) begin
                if (usr && !eu) begin ef = 1; ec = 3; end
                else if (wr && !ew) begin ef = 1; ec = 2; end
            end
            if (!ef) begin
                exp_pa = pde[7] ? {pde[31:22], va[21:0]} : {pte[31:12], va[11:0]};
                epwt = leaf[3]; epcd = leaf[4];
                if (!pde[7] && !pde[5]) begin new_pde = pde | 32'h20; exp_w++; end
                if (!leaf[5] || (wr && !leaf[6])) begin
                    new_leaf = leaf | 32'h20 | (wr ? 32'h40 : 32'h0);
                    exp_w++;
                end else begin
                    new_leaf = leaf;
                end
                if (pde[7]) new_pde = new_leaf;
            end
        end
        exp_lat += exp_w;
        w0 = wcount;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr; req_base = base;
        @(posedge clk);
        lat = 0; done = 0;
        for (int i = 0; i < 400 && !done; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (resp_valid) done = 1; else lat++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL R10 no response actual=0 expected=1");
        end else begin
            check("R3 fault flag", 32'(resp_fault), 32'(ef));
            if (ef) check("R3/R4 fault cause", 32'(resp_cause), 32'(ec));
            check("R2/R5 physical address", resp_paddr, exp_pa);
            check("R8 write-through", 32'(resp_pwt), 32'(epwt));
            check("R8 cache-disable", 32'(resp_pcd), 32'(epcd));
            check("R1/R6 top entry in memory", mem[widx(pa1)], new_pde);
            if (pde[0] && !pde[7]) check("R7 final entry in memory", mem[widx(pa2)], new_leaf);
            check("R7 write-back count", 32'(wcount - w0), 32'(exp_w));
            if (lat_chk) check("R10 latency", 32'(lat), 32'(exp_lat));
        end
    endtask

    task automatic put(logic [19:0] base, logic [31:0] va, logic [31:0] pde, logic [31:0] pte);
        mem[widx({base, va[31:22], 2'b00})] = pde;
        if (!pde[7]) mem[widx({pde[31:12], va[21:12], 2'b00})] = pte;
    endtask

    task automatic random_walk(bit lat_chk);
        logic [31:0] va, pde, pte;
        logic [1:0] fr;
        va = $urandom;
        pde = $urandom & 32'hFF;
        pde[0] = ($urandom % 8) != 0;
        pde[7] = ($urandom % 4) == 0;
        if (pde[7]) begin
            pde[31:12] = 20'($urandom);
        end else begin
            fr = 2'(1 + $urandom % 3);
            pde[31:12] = {18'd0, fr};
        end
        pte = ($urandom & 32'hFFFFF000) | ($urandom & 32'hFF);
        pte[0] = ($urandom % 8) != 0;
        put(20'd0, va, pde, pte);
        run_walk(20'd0, va, 1'($urandom), 1'($urandom), lat_chk);
    endtask

    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 4096; i++) mem[i] = 32'd0;
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
        req_user = 1'b0; req_base = '0; mem_ready = 1'b0; mem_rdata = '0;
        // Memory model: grant at falling edges, commit writes on grant.
        fork
            forever begin
                @(negedge clk);
                if (mem_valid && (zero_wait || ($urandom % 3) == 0)) begin
                    mem_ready = 1'b1;
                    if (mem_write) begin
                        mem[widx(mem_addr)] = mem_wdata;
                        wcount++;
                        mem_rdata = 32'd0;
                    end else begin
                        mem_rdata = mem[widx(mem_addr)];
                    end
                end else begin
                    mem_ready = 1'b0;
                    mem_rdata = 32'hDEAD_BEEF;
                end
            end
        join_none
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset req_ready", 32'(req_ready), 32'd1);
        check("R10 reset resp_valid", 32'(resp_valid), 32'd0);
        check("R9 reset mem_valid", 32'(mem_valid), 32'd0);

        // Directed cases, zero-wait memory, latency checked.
        put(20'd0, 32'h0040_1ABC, 32'h0000_1027, 32'hABCD_E067);   // R2 all flags set: no writes
        run_walk(20'd0, 32'h0040_1ABC, 1'b0, 1'b1, 1'b1);
        put(20'd0, 32'h0080_2123, 32'h0000_2003, 32'h1234_5003);   // R6 R7 both write-backs
        run_walk(20'd0, 32'h0080_2123, 1'b1, 1'b0, 1'b1);
        put(20'd0, 32'hC012_3456, 32'hFFC0_0087, 32'h0);           // R5 large page write
        run_walk(20'd0, 32'hC012_3456, 1'b1, 1'b0, 1'b1);
        put(20'd0, 32'h0100_0000, 32'h0000_3086, 32'h0);           // R3 top absent
        run_walk(20'd0, 32'h0100_0000, 1'b0, 1'b0, 1'b1);
        put(20'd0, 32'h0140_5000, 32'h0000_1007, 32'h5555_5006);   // R3 second absent
        run_walk(20'd0, 32'h0140_5000, 1'b0, 1'b1, 1'b1);
        put(20'd0, 32'h0180_6000, 32'h0000_2007, 32'h6666_6001);   // R4 user beats write
        run_walk(20'd0, 32'h0180_6000, 1'b1, 1'b1, 1'b1);
        put(20'd0, 32'h01C0_7000, 32'h0000_3025, 32'h7777_7067);   // R4 top not writable
        run_walk(20'd0, 32'h01C0_7000, 1'b1, 1'b0, 1'b1);
        put(20'd0, 32'h0200_8000, 32'h0000_1021, 32'h8888_8061);   // R4 supervisor read
        run_walk(20'd0, 32'h0200_8000, 1'b0, 1'b0, 1'b1);
        put(20'd0, 32'h0240_9000, 32'h0000_2027, 32'h9999_9007);   // R7 read sets A not D
        run_walk(20'd0, 32'h0240_9000, 1'b0, 1'b1, 1'b1);
        put(20'd0, 32'h0280_A000, 32'h0000_3027, 32'hAAAA_A037);   // R8 leaf cache bits
        run_walk(20'd0, 32'h0280_A000, 1'b1, 1'b1, 1'b1);
        put(20'd2, 32'h02C0_BFFF, 32'h0000_1023, 32'hBBBB_B023);   // R1 nonzero base
        run_walk(20'd2, 32'h02C0_BFFF, 1'b0, 1'b0, 1'b1);
        put(20'd0, 32'h0300_C000, 32'h0300_00E3, 32'h0);           // R5 large page, flags set
        run_walk(20'd0, 32'h0300_C000, 1'b1, 1'b0, 1'b1);

        for (int i = 0; i < 150; i++) random_walk(1'b1);
        zero_wait = 1'b0;
        for (int i = 0; i < 250; i++) random_walk(1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule